// File: doc/BRIEF.md
# Dual-Order Burst Beat Address Generator

This block produces the low-order beat address for a short memory burst. A start value is captured when an address strobe is qualified by an active chip select. Each later advance request then moves the output to the next beat of the burst. A static order input chooses one of two beat orders. The interleaved order flips the start value's bits according to the beat number. The linear order counts upward from the start and wraps around.

Two strobes can start a burst: one from a processor and one from a cache controller. Both need chip select, and a load always wins over an advance in the same cycle. A processor strobe seen while chip select is inactive has no effect at all. A controller strobe seen while chip select is inactive does not load. All control pins are plain active-low levels sampled on the rising clock edge, and the output is a plain registered-state level. There is no data stream and no handshake. The beat width is a parameter; the default of 2 bits gives a four-beat burst.

Top module: `burst_beat_gen`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears the captured start and the beat count, so beat_addr reads 0 after the edge.
- R2: With cs_n low and pstrb_n low at a rising edge, the start value is loaded from start_addr and the beat count returns to 0. beat_addr then equals start_addr in either order.
- R3: With cs_n low, pstrb_n high and cstrb_n low at a rising edge, the same load as R2 takes place.
- R4: With order_sel = 1 (interleaved), beat k of a burst is start XOR k.
- R5: With order_sel = 0 (linear), beat k of a burst is (start + k) modulo 2^BEAT_W.
- R6: When no load takes place and adv_n is high at a rising edge, beat_addr keeps its previous value.
- R7: When a load takes place at an edge, adv_n is ignored at that edge. The burst restarts at beat 0.
- R8: With cs_n high, pstrb_n is ignored: it neither loads nor blocks an advance with adv_n low.
- R9: With cs_n high and cstrb_n low, no load takes place. An advance with adv_n low still takes effect.
- R10: After 2^BEAT_W advances, the burst wraps and beat_addr again equals the start value.
- R11: order_sel acts without a clock edge. When it changes mid-burst, beat_addr is re-formed at once from the same start value and beat count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| pstrb_n | input | 1 | Processor address strobe, active low |
| cstrb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Advance request, active low |
| order_sel | input | 1 | Beat order: 1 selects interleaved, 0 selects linear |
| start_addr | input | BEAT_W | Start beat value captured on a load |
| beat_addr | output | BEAT_W | Current beat address |

## Verification
The bench builds the block with the default BEAT_W of 2. At this width every start value, both orders and all sixteen combinations of the four active-low control pins can be swept from every starting state. This brings each priority case within reach: load against advance, a strobe with select inactive, and full wraparound after four beats. The expected beat is computed arithmetically in the bench as XOR or modular sum of start and beat count.

// File: rtl/burst_beat_pkg.sv
package burst_beat_pkg;

  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } beat_order_e;

endpackage

// File: rtl/bb_strobe_qual.sv
module bb_strobe_qual (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic pstrb_n,
  input  logic cstrb_n,
  input  logic adv_n,
  output logic load_o,
  output logic step_o
);

  logic sel_act;
  logic any_strobe;

  always_comb begin
    sel_act    = ~cs_n;
    any_strobe = ~pstrb_n | ~cstrb_n;
    load_o     = sel_act & any_strobe;
    step_o     = ~adv_n & ~load_o;
  end

  // R7: a load and a step never coincide
  assert_load_beats_step_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({load_o, step_o}));

  // R8 / R9: no load while chip select is inactive
  assert_desel_noload_R8: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !load_o);

endmodule

// File: rtl/bb_beat_track.sv
module bb_beat_track #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [BEAT_W-1:0] start_i,
  output logic [BEAT_W-1:0] start_q,
  output logic [BEAT_W-1:0] idx_q
);

  localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      idx_q   <= '0;
    end else if (load_i) begin
      start_q <= start_i;
      idx_q   <= '0;
    end else if (step_i) begin
      idx_q   <= idx_q + ONE;
    end
  end

  // R2: a load restarts the beat count
  assert_load_clears_idx_R2: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (idx_q == '0));

  // R10: a step moves the count by exactly one, wrapping
  assert_step_wraps_R10: assert property (@(posedge clk) disable iff (rst)
    (step_i && !load_i) |=> (idx_q == $past(idx_q) + ONE));

  // R6: no load and no step keeps all state
  assert_idle_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (!step_i && !load_i) |=> ($stable(idx_q) && $stable(start_q)));

endmodule

// File: rtl/bb_addr_form.sv
module bb_addr_form
  import burst_beat_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start_i,
  input  logic [BEAT_W-1:0] idx_i,
  input  beat_order_e       order_i,
  output logic [BEAT_W-1:0] addr_o
);

  logic [BEAT_W-1:0] lin_addr;
  logic [BEAT_W-1:0] ilv_addr;

  genvar b;
  generate
    for (b = 0; b < BEAT_W; b++) begin : g_ilv
      assign ilv_addr[b] = start_i[b] ^ idx_i[b];
    end
  endgenerate

  assign lin_addr = start_i + idx_i;

  always_comb begin
    case (order_i)
      ORDER_INTERLEAVE: addr_o = ilv_addr;
      default:          addr_o = lin_addr;
    endcase
  end

endmodule

// File: rtl/burst_beat_gen.sv
module burst_beat_gen
  import burst_beat_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              pstrb_n,
  input  logic              cstrb_n,
  input  logic              adv_n,
  input  logic              order_sel,
  input  logic [BEAT_W-1:0] start_addr,
  output logic [BEAT_W-1:0] beat_addr
);

  logic              load_w;
  logic              step_w;
  logic [BEAT_W-1:0] start_w;
  logic [BEAT_W-1:0] idx_w;
  beat_order_e       order_w;

  assign order_w = beat_order_e'(order_sel);

  bb_strobe_qual u_qual (
    .clk     (clk),
    .rst     (rst),
    .cs_n    (cs_n),
    .pstrb_n (pstrb_n),
    .cstrb_n (cstrb_n),
    .adv_n   (adv_n),
    .load_o  (load_w),
    .step_o  (step_w)
  );

  bb_beat_track #(.BEAT_W(BEAT_W)) u_track (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load_w),
    .step_i  (step_w),
    .start_i (start_addr),
    .start_q (start_w),
    .idx_q   (idx_w)
  );

  bb_addr_form #(.BEAT_W(BEAT_W)) u_form (
    .start_i (start_w),
    .idx_i   (idx_w),
    .order_i (order_w),
    .addr_o  (beat_addr)
  );

  // R1: reset leaves beat address zero
  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> (beat_addr == '0));

  // R2 / R3: qualified strobe puts the start value on the output
  assert_strobe_loads_R3: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && (!pstrb_n || !cstrb_n)) |=> (beat_addr == $past(start_addr)));

  // R6: idle cycle holds the output while the order is unchanged
  assert_adv_high_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (adv_n && !(!cs_n && (!pstrb_n || !cstrb_n))) |=>
      ((beat_addr == $past(beat_addr)) || (order_sel != $past(order_sel))));

  // R8: inactive select never changes the captured start
  assert_desel_keeps_start_R8: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> $stable(start_w));

endmodule

// File: tb/burst_beat_gen_tb_top.sv
module burst_beat_gen_tb_top;

  logic       clk = 1'b0;
  logic       rst, cs_n, pstrb_n, cstrb_n, adv_n, order_sel;
  logic [1:0] start_addr;
  logic [1:0] beat_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int m_s    = 0;
  int m_i    = 0;

  always #10 clk = ~clk;

  burst_beat_gen #(.BEAT_W(2)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .cs_n       (cs_n),
    .pstrb_n    (pstrb_n),
    .cstrb_n    (cstrb_n),
    .adv_n      (adv_n),
    .order_sel  (order_sel),
    .start_addr (start_addr),
    .beat_addr  (beat_addr)
  );

  function automatic logic [1:0] expect_addr();
    if (order_sel) return 2'(m_s ^ m_i);
    return 2'((m_s + m_i) % 4);
  endfunction

  task automatic check(input string tag);
    logic [1:0] e;
    e = expect_addr();
    checks++;
    if (beat_addr !== e) begin
      fails++;
      $display("FAIL %s: beat_addr=%0d expected=%0d", tag, beat_addr, e);
    end
  endtask

  task automatic cyc(input logic r, input logic c, input logic p, input logic cc,
                     input logic a, input logic [1:0] ad);
    rst = r; cs_n = c; pstrb_n = p; cstrb_n = cc; adv_n = a; start_addr = ad;
    @(posedge clk);
    if (r) begin
      m_s = 0; m_i = 0;
    end else if (!c && (!p || !cc)) begin
      m_s = int'(ad); m_i = 0;
    end else if (!a) begin
      m_i = (m_i + 1) % 4;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, actual=expired expected=finished");
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1; cs_n = 1; pstrb_n = 1; cstrb_n = 1; adv_n = 1; order_sel = 1;
    start_addr = 2'd3;
    @(negedge clk);
    cyc(1, 1, 1, 1, 1, 2'd3);
    check("R1 reset");
    cyc(0, 1, 1, 1, 1, 2'd3);
    check("R1 after reset");

    // Bursts in both orders from every start value
    for (int o = 0; o < 2; o++) begin
      for (int s = 0; s < 4; s++) begin
        order_sel = o[0];
        cyc(0, 0, 0, 1, 1, 2'(s));
        check("R2 processor load");
        for (int k = 1; k <= 4; k++) begin
          cyc(0, 1, 1, 1, 0, 2'(3 - s));
          if (k == 4)      check("R10 wrap");
          else if (o == 1) check("R4 interleaved beat");
          else             check("R5 linear beat");
        end
        cyc(0, 1, 1, 1, 1, 2'(s ^ 1));
        check("R6 hold");
      end
    end

    // Controller strobe loads
    for (int s = 0; s < 4; s++) begin
      cyc(0, 0, 1, 0, 1, 2'(s));
      check("R3 controller load");
    end

    // All control combinations from a mid-burst state
    for (int o = 0; o < 2; o++) begin
      for (int s = 0; s < 4; s++) begin
        for (int cmb = 0; cmb < 16; cmb++) begin
          logic c, p, cc, a;
          c = cmb[3]; p = cmb[2]; cc = cmb[1]; a = cmb[0];
          order_sel = o[0];
          cyc(0, 0, 0, 0, 1, 2'(s));
          cyc(0, 1, 1, 1, 0, 2'(s));
          cyc(0, c, p, cc, a, 2'(~s));
          if (!c && (!p || !cc) && !a) check("R7 load over advance");
          else if (!c && !p)            check("R2 load");
          else if (!c && !cc)           check("R3 load");
          else if (c && !p)             check("R8 processor strobe deselected");
          else if (c && !cc)            check("R9 controller strobe deselected");
          else if (a)                   check("R6 hold");
          else if (o == 1)              check("R4 step");
          else                          check("R5 step");
        end
      end
    end

    // Order change mid-burst
    order_sel = 1'b1;
    cyc(0, 0, 0, 1, 1, 2'd1);
    cyc(0, 1, 1, 1, 0, 2'd0);
    check("R11 interleaved before change");
    order_sel = 1'b0;
    #1;
    check("R11 linear after change");
    order_sel = 1'b1;
    #1;
    check("R11 interleaved again");

    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

endmodule